// File: doc/BRIEF.md
# IEC-60958 Audio Subframe Packer

This block turns a stream of interleaved 24-bit PCM samples for 2 to 8 channels into 29-bit subframe words ready for a line encoder. For each sample it adds a channel-status bit, an even-parity bit and a block-start flag. The channel-status bit comes from a 192-frame block that the block builds itself from a 32-bit consumer pattern, with each channel's own number written into that channel's copy. A second mode takes subframe words that are already formed, carrying a preamble code in their low nibble, and only repacks them.

Samples enter on a valid/ready stream, one 32-bit word per channel, in channel order. Each accepted word produces exactly one output word on a valid/ready stream one cycle later. Back-pressure from the output stalls the input. A restart pulse, or any change of the mode select, realigns the packer to channel 0 of frame 0.

Top module: `iec_subframe_packer`

## Requirements
- R1: In PCM mode the output carries input bits 23:0 unchanged in bits 23:0. Bits 25:24 (user, validity) are 0, bits 31:29 are 0, and input bits 31:24 have no effect on the output.
- R2: In PCM mode output bit 27 is the XOR of output bits 26:0, so bits 27:0 have even parity.
- R3: Output bit 26 in frame k (0..191) is bit k of the 32-bit pattern for k below 32, where bit k is bit (k mod 8) of byte k/8, LSB first. For k from 32 to 191 it is 0.
- R4: For channel c (0-based), pattern bits 23:20 are replaced by the value c+1 before the bit is chosen. In frames 20 to 23, bit 26 is therefore bit (k-20) of c+1.
- R5: Output bit 28 is 1 only on channel 0 of frame 0 of each block.
- R6: The frame index advances by one after every N accepted samples, where N is the effective channel count. It wraps from 191 to 0, so frame 192 behaves as frame 0.
- R7: A channel-count input of 2 to 8 gives N equal to that value. Any other value gives N = 2.
- R8: In pass-through mode (mode = 1) the output is the input shifted right by 4. Bit 28 is set from input bit 3 (the block-start preamble code 8), bits 31:29 are 0, and the frame and channel counters do not advance.
- R9: While restart is high, and in any cycle where mode differs from its value in the previous cycle, the counters return to channel 0, frame 0. A word accepted in that cycle is packed as channel 0 of frame 0.
- R10: in_ready equals (not out_valid) or out_ready. A stalled output word holds both out_valid and its value. Each accepted input gives exactly one output, in order, one cycle after acceptance.
- R11: After reset, out_valid is 0, in_ready is 1, and the packer starts at channel 0, frame 0, in PCM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Realign to channel 0, frame 0 |
| mode | input | 1 | 0 = PCM packing, 1 = pass-through |
| chan_count | input | 4 | Channels per frame (2 to 8, otherwise 2) |
| cs_pattern | input | 32 | Consumer channel-status bytes 0 to 3 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | PCM sample or preformed subframe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 32 | Packed subframe word |

## Verification
The bench runs a full 192-frame wrap in stereo, so a counter that wraps at the wrong value shows a misplaced block-start flag on the 193rd frame. Eight-channel frames through indices 20 to 23 catch a channel number that is not patched, or is patched off by one, because every channel then shows the same status bits. Out-of-range channel counts, restarts that land on a word, and mode flips each test the alignment rules; a wrong clamp or a missed flush would shift every later status bit. Random and forced back-pressure show whether a word is lost, repeated or changed while the output is stalled.

// File: rtl/iec_pack_pkg.sv
// Shared constants and types for the subframe packer.
// Assumes a 192-frame status block and at most 8 channels.
package iec_pack_pkg;
    localparam int WORD_W    = 32;
    localparam int AUDIO_W   = 24;
    localparam int BLOCK_LEN = 192;
    localparam int MIN_CH    = 2;
    localparam int MAX_CH    = 8;
    localparam int PAT_W     = 32;
    localparam int CNT_W     = 4;
    localparam int FRAME_W   = $clog2(BLOCK_LEN);
    localparam int CH_W      = $clog2(MAX_CH);

    // Output bit positions; a downstream line coder decodes these.
    localparam int POS_V = 24;
    localparam int POS_U = 25;
    localparam int POS_C = 26;
    localparam int POS_P = 27;
    localparam int POS_B = 28;

    // Position of the channel-number field inside the status pattern.
    localparam int CHNUM_LO = 20;
    localparam int CHNUM_W  = 4;

    typedef enum logic {
        PK_PCM  = 1'b0,
        PK_PASS = 1'b1
    } pack_mode_e;
endpackage

// File: rtl/iec_pack_seq.sv
// Frame and channel position tracker.
// Gives the channel index and frame index for the word accepted this cycle,
// already cleared when restart is high or the mode changed. Assumes the
// channel count input is sampled per word; values outside range act as 2.
module iec_pack_seq
    import iec_pack_pkg::*;
#(
    parameter int N_FRAMES = BLOCK_LEN,
    parameter int N_MAXCH  = MAX_CH,
    localparam int FW = $clog2(N_FRAMES),
    localparam int CW = $clog2(N_MAXCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  pack_mode_e       mode,
    input  logic [CNT_W-1:0] chan_count,
    input  logic             accept,
    output logic [CW-1:0]    ch_now,
    output logic [FW-1:0]    frame_now
);
    logic [CW-1:0]    ch_q;
    logic [FW-1:0]    frame_q;
    pack_mode_e       mode_q;
    logic             flush;
    logic [CNT_W-1:0] n_eff;
    logic             last_ch;

    // Clamp the channel count to the supported range.
    always_comb begin
        if (chan_count >= CNT_W'(MIN_CH) && chan_count <= CNT_W'(N_MAXCH))
            n_eff = chan_count;
        else
            n_eff = CNT_W'(MIN_CH);
    end

    // Effective position for this cycle, cleared by restart or a mode flip.
    always_comb begin
        flush     = restart || (mode != mode_q);
        ch_now    = flush ? '0 : ch_q;
        frame_now = flush ? '0 : frame_q;
        last_ch   = ({1'b0, ch_now} >= (n_eff - CNT_W'(1)));
    end

    // Advance the position after each PCM sample, wrapping channel and frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q    <= '0;
            frame_q <= '0;
            mode_q  <= PK_PCM;
        end else begin
            mode_q <= mode;
            if (accept && mode == PK_PCM) begin
                if (last_ch) begin
                    ch_q    <= '0;
                    frame_q <= (frame_now == FW'(N_FRAMES - 1)) ? '0 : frame_now + FW'(1);
                end else begin
                    ch_q    <= ch_now + CW'(1);
                    frame_q <= frame_now;
                end
            end else if (flush) begin
                ch_q    <= '0;
                frame_q <= '0;
            end
        end
    end

    a_r6_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q < FW'(N_FRAMES));

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !accept) |=> (ch_q == '0 && frame_q == '0));

    a_r8_pass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PK_PASS && mode_q == PK_PASS && !restart) |=> ($stable(ch_q) && $stable(frame_q)));

    a_r7_chan_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == PK_PCM && !flush && {1'b0, ch_q} >= (n_eff - CNT_W'(1))) |=> ch_q == '0);
endmodule

// File: rtl/iec_pack_csbit.sv
// Channel-status bit selector.
// Picks the status bit for a frame index from the 32-bit consumer pattern,
// with the channel number (c+1) written over the channel field first.
// Frames past the supplied pattern give 0.
module iec_pack_csbit
    import iec_pack_pkg::*;
#(
    parameter int N_FRAMES = BLOCK_LEN,
    parameter int N_MAXCH  = MAX_CH,
    localparam int FW = $clog2(N_FRAMES),
    localparam int CW = $clog2(N_MAXCH),
    localparam int IW = $clog2(PAT_W)
) (
    input  logic [PAT_W-1:0] pattern,
    input  logic [CW-1:0]    ch,
    input  logic [FW-1:0]    frame,
    output logic             cs_bit
);
    logic [PAT_W-1:0]   patched;
    logic [CHNUM_W-1:0] ch_num;

    // Build this channel's copy of the pattern and pick the frame's bit.
    always_comb begin
        ch_num  = CHNUM_W'(ch) + CHNUM_W'(1);
        patched = pattern;
        patched[CHNUM_LO +: CHNUM_W] = ch_num;
        if (frame < FW'(PAT_W))
            cs_bit = patched[frame[IW-1:0]];
        else
            cs_bit = 1'b0;
    end
endmodule

// File: rtl/iec_pack_fmt.sv
// Subframe word formatter.
// PCM: audio in the low 24 bits, status, parity and block-start added.
// Pass-through: preformed word moved down by 4, block-start from the
// preamble code bit. Purely combinational.
module iec_pack_fmt
    import iec_pack_pkg::*;
#(
    parameter int N_FRAMES = BLOCK_LEN,
    parameter int N_MAXCH  = MAX_CH,
    localparam int FW = $clog2(N_FRAMES),
    localparam int CW = $clog2(N_MAXCH)
) (
    input  pack_mode_e        mode,
    input  logic [WORD_W-1:0] din,
    input  logic [CW-1:0]     ch,
    input  logic [FW-1:0]     frame,
    input  logic              cs_bit,
    output logic [WORD_W-1:0] dout
);
    // Assemble the output word for the selected mode.
    always_comb begin
        dout = '0;
        if (mode == PK_PCM) begin
            dout[AUDIO_W-1:0] = din[AUDIO_W-1:0];
            dout[POS_V]       = 1'b0;
            dout[POS_U]       = 1'b0;
            dout[POS_C]       = cs_bit;
            dout[POS_P]       = cs_bit ^ (^din[AUDIO_W-1:0]);
            dout[POS_B]       = (ch == '0) && (frame == '0);
        end else begin
            dout[WORD_W-5:0] = din[WORD_W-1:4];
            dout[POS_B]      = din[3];
        end
    end
endmodule

// File: rtl/iec_subframe_packer.sv
// Top of the subframe packer.
// Tracks the frame/channel position, picks the status bit, formats the word
// and holds it in a single output register with valid/ready flow control.
// Assumes input words arrive in channel order starting at channel 0.
module iec_subframe_packer
    import iec_pack_pkg::*;
#(
    parameter int N_FRAMES = BLOCK_LEN,
    parameter int N_MAXCH  = MAX_CH,
    localparam int FW = $clog2(N_FRAMES),
    localparam int CW = $clog2(N_MAXCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              mode,
    input  logic [CNT_W-1:0]  chan_count,
    input  logic [PAT_W-1:0]  cs_pattern,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    pack_mode_e        mode_e;
    logic              accept;
    logic [CW-1:0]     ch_now;
    logic [FW-1:0]     frame_now;
    logic              cs_bit;
    logic [WORD_W-1:0] word_next;
    logic              out_pcm;

    // Decode mode and the input handshake.
    always_comb begin
        mode_e   = pack_mode_e'(mode);
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    iec_pack_seq #(.N_FRAMES(N_FRAMES), .N_MAXCH(N_MAXCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mode(mode_e),
        .chan_count(chan_count), .accept(accept),
        .ch_now(ch_now), .frame_now(frame_now)
    );

    iec_pack_csbit #(.N_FRAMES(N_FRAMES), .N_MAXCH(N_MAXCH)) u_csbit (
        .pattern(cs_pattern), .ch(ch_now), .frame(frame_now), .cs_bit(cs_bit)
    );

    iec_pack_fmt #(.N_FRAMES(N_FRAMES), .N_MAXCH(N_MAXCH)) u_fmt (
        .mode(mode_e), .din(in_data), .ch(ch_now), .frame(frame_now),
        .cs_bit(cs_bit), .dout(word_next)
    );

    // Output register: load on accept, drop when the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_pcm   <= 1'b1;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= word_next;
            out_pcm   <= (mode_e == PK_PCM);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r1_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[WORD_W-1:POS_B+1] == '0);

    a_r2_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pcm) |-> (^out_data[POS_P:0]) == 1'b0);

    a_r1_vu_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pcm) |-> out_data[POS_U:POS_V] == 2'b00);
endmodule

// File: tb/iec_subframe_packer_bench.sv
module iec_subframe_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        mode = 1'b0;
    logic [3:0]  chan_count = 4'd2;
    logic [31:0] cs_pattern = 32'h0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = 32'h0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int total = 0;
    int bad = 0;
    int sent = 0;
    int got = 0;
    bit bp_rand = 0;
    bit bp_hold = 0;
    string cur_tag = "R1";

    logic [31:0] exp_q[$];
    string       tag_q[$];

    int m_ch = 0;
    int m_fr = 0;

    always #4 clk = ~clk;

    iec_subframe_packer u_iec_subframe_packer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mode(mode),
        .chan_count(chan_count), .cs_pattern(cs_pattern),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic int eff_n(input logic [3:0] c);
        return (c >= 2 && c <= 8) ? int'(c) : 2;
    endfunction

    // Expected word from the requirements (R1..R5, R8).
    function automatic logic [31:0] expect_word(input logic [31:0] d, input int ch, input int fr, input bit pass);
        logic [31:0] w;
        logic c;
        logic [3:0] num;
        w = 32'h0;
        if (pass) begin
            w = d >> 4;
            w[28] = d[3];
        end else begin
            num = 4'(ch + 1);
            if (fr >= 20 && fr <= 23) c = num[fr - 20];
            else if (fr < 32) c = cs_pattern[fr];
            else c = 1'b0;
            w[23:0] = d[23:0];
            w[26] = c;
            w[27] = c ^ (^d[23:0]);
            w[28] = (ch == 0 && fr == 0);
        end
        return w;
    endfunction

    // Driver: present one word, push its expected result when accepted.
    task automatic send(input logic [31:0] d, input bit rs);
        bit acc;
        acc = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        restart  = rs;
        while (!acc) begin
            #1;
            if (rs) begin m_ch = 0; m_fr = 0; end
            acc = in_ready;
            if (acc) begin
                exp_q.push_back(expect_word(d, m_ch, m_fr, mode));
                tag_q.push_back(cur_tag);
                sent++;
                if (!mode) begin
                    if (m_ch >= eff_n(chan_count) - 1) begin
                        m_ch = 0;
                        m_fr = (m_fr == 191) ? 0 : m_fr + 1;
                    end else m_ch++;
                end
            end
            @(posedge clk);
            if (!acc) @(negedge clk);
        end
        #1;
        in_valid = 1'b0;
        restart  = 1'b0;
    endtask

    task automatic set_mode(input bit m);
        @(negedge clk);
        mode = m;
        m_ch = 0;
        m_fr = 0;
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input int words);
        for (int i = 0; i < words; i++) send($urandom, 1'b0);
    endtask

    // Back-pressure driver.
    initial begin
        forever begin
            @(negedge clk);
            if (bp_hold) out_ready = 1'b0;
            else if (bp_rand) out_ready = ($urandom % 3) != 0;
            else out_ready = 1'b1;
        end
    end

    // Monitor: compare each word taken by the consumer with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && out_valid && out_ready) begin
                got++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected output", out_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, out_data, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        cs_pattern = 32'hA5C3_9E17;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R11 out_valid after reset", {31'h0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R11 in_ready after reset", {31'h0, in_ready}, 32'h1);

        // Stereo across a full block wrap, garbage in bits 31:24.
        cur_tag = "R1 R2 R3 R5 R6 R11";
        chan_count = 4'd2;
        burst(2 * 200);
        drain();

        // Eight channels through the patched frames, random back-pressure.
        cur_tag = "R4 R3 R10";
        chan_count = 4'd8;
        bp_rand = 1;
        send($urandom, 1'b1);
        burst(8 * 30 - 1);
        drain();
        bp_rand = 0;

        // Five channels.
        cur_tag = "R4 R6";
        chan_count = 4'd5;
        send($urandom, 1'b1);
        burst(5 * 25 - 1);
        drain();

        // Out-of-range channel counts behave as two channels.
        cur_tag = "R7 count 0";
        chan_count = 4'd0;
        send($urandom, 1'b1);
        burst(2 * 24 - 1);
        cur_tag = "R7 count 9";
        chan_count = 4'd9;
        send($urandom, 1'b1);
        burst(2 * 24 - 1);
        drain();

        // Restart landing on a word mid-frame.
        cur_tag = "R9 restart on word";
        chan_count = 4'd6;
        burst(7);
        send(32'h00AB_CDEF, 1'b1);
        burst(12);
        drain();

        // Pass-through words with each preamble code.
        cur_tag = "R8";
        set_mode(1'b1);
        bp_rand = 1;
        send(32'hF123_4568, 1'b0);
        send(32'h0ABC_DEF4, 1'b0);
        send(32'h5555_5552, 1'b0);
        burst(20);
        drain();
        bp_rand = 0;

        // Mode flip back realigns to channel 0 frame 0.
        cur_tag = "R9 mode change";
        chan_count = 4'd3;
        set_mode(1'b0);
        burst(3 * 4);
        drain();

        // Forced stall: output held, input blocked.
        cur_tag = "R10";
        bp_hold = 1;
        send(32'h0012_3456, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #2;
            check(out_valid == 1'b1, "R10 valid held", {31'h0, out_valid}, 32'h1);
            check(in_ready == 1'b0, "R10 in_ready low in stall", {31'h0, in_ready}, 32'h0);
            check(out_data == exp_q[0], "R10 data held", out_data, exp_q[0]);
        end
        bp_hold = 0;
        burst(5);
        drain();
        check(got == sent, "R10 one output per input", 32'(got), 32'(sent));
        finish_run();
    end
endmodule